// File: doc/BRIEF.md
# Dual-Sided Inter-Processor Messaging Unit

This block lets two processors on one clock exchange data words and doorbells. Each processor has its own 32-bit register port, and the two ports are mirror images of each other. A word written into one of a side's transmit slots can be read from the matching receive slot on the other side. The sending side sees the slot as busy until the receiver has read it. Each side can also raise up to four doorbell requests. Each request shows up as a pending bit on the peer, and the peer clears it by writing a one to that bit.

Each side has its own enable masks for pending doorbells, full receive slots and empty transmit slots. From these it drives a single interrupt line. Software may poll the status registers instead of using the interrupt. A read returns its data in the cycle after the request. Either side can request a reset of the whole unit, and its progress can be read back. Data words held in the slots are not cleared by any reset.

Top module: `ipc_msg_unit`

## Requirements
- R1: The word at offset 0x004 always reads 0x0000_0404: bits [7:0] give the transmit slot count (4) and bits [15:8] give the receive slot count (4).
- R2: A write to offset 0x200+4n on one side stores the word in slot n. It sets bit n of the peer's receive status (0x12C) and clears bit n of the writer's transmit status (0x124). The peer reads the word at 0x280+4n.
- R3: A read of 0x280+4n clears bit n of the reader's receive status and sets bit n of the peer's transmit status.
- R4: Writing ones to the doorbell request register (0x114) sets the same bits in the peer's doorbell pending register (0x118). A request bit reads back 1 until the peer clears its pending bit.
- R5: The pending register is write-one-to-clear. Only the bits written as 1 clear, and the sender's matching request bit drops in the same cycle.
- R6: A side's irq is high when any set bit of pending&enable (0x118 & 0x110), receive status & receive enable (0x12C & 0x128) or transmit status & transmit enable (0x124 & 0x120) is present. irq follows that status one cycle later.
- R7: Writes to 0x004, 0x00C, 0x118 with zero data, 0x124, 0x12C and 0x280-0x28C change nothing.
- R8: After rst, every control, request, pending and receive status bit is 0. Transmit status is 0xF, both irq outputs are 0, and read data is 0.
- R9: If one side writes slot n in the same cycle that the peer reads slot n, the read returns the older word. The slot then stays full and holds the new word.
- R10: If a side raises doorbell n in the same cycle that the peer clears pending bit n, both the pending bit and the request bit stay set.
- R11: Writing 1 to bit 0 of 0x008 clears all unit state except data words for RST_CYCLES cycles. During that time bit 0 of 0x008 and bit 0 of 0x00C read 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst | input | 1 | Synchronous active-high reset |
| a_req | input | 1 | Side A access strobe |
| a_we | input | 1 | Side A write (1) or read (0) |
| a_addr | input | 12 | Side A byte offset |
| a_wdata | input | 32 | Side A write data |
| a_rdata | output | 32 | Side A read data, valid the cycle after a read |
| a_irq | output | 1 | Side A interrupt |
| b_req | input | 1 | Side B access strobe |
| b_we | input | 1 | Side B write (1) or read (0) |
| b_addr | input | 12 | Side B byte offset |
| b_wdata | input | 32 | Side B write data |
| b_rdata | output | 32 | Side B read data, valid the cycle after a read |
| b_irq | output | 1 | Side B interrupt |

## Verification
Two pairs of functions can land on the same edge. The first pair is a transmit write on one port and a receive read of the same slot on the other. The second pair is a doorbell raise and the peer's write-one-to-clear of that doorbell. The bench drives both ports in a single cycle to provoke each case. It judges the data case by checking that the read returns the older word and that the slot is still full with the new word afterwards. It judges the doorbell case by checking that both the request bit and the pending bit remain set.

// File: rtl/ipc_mu_pkg.sv
package ipc_mu_pkg;
  localparam int ADDR_W = 12;

  localparam logic [ADDR_W-1:0] OFS_PARAM = 12'h004;
  localparam logic [ADDR_W-1:0] OFS_MCTRL = 12'h008;
  localparam logic [ADDR_W-1:0] OFS_MSTAT = 12'h00C;
  localparam logic [ADDR_W-1:0] OFS_GIER  = 12'h110;
  localparam logic [ADDR_W-1:0] OFS_GCR   = 12'h114;
  localparam logic [ADDR_W-1:0] OFS_GSR   = 12'h118;
  localparam logic [ADDR_W-1:0] OFS_TCR   = 12'h120;
  localparam logic [ADDR_W-1:0] OFS_TSR   = 12'h124;
  localparam logic [ADDR_W-1:0] OFS_RCR   = 12'h128;
  localparam logic [ADDR_W-1:0] OFS_RSR   = 12'h12C;
  localparam logic [ADDR_W-1:0] OFS_TX    = 12'h200;
  localparam logic [ADDR_W-1:0] OFS_RX    = 12'h280;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_PARAM, SEL_MCTRL, SEL_MSTAT, SEL_GIER, SEL_GCR,
    SEL_GSR, SEL_TCR, SEL_TSR, SEL_RCR, SEL_RSR
  } reg_sel_e;

  function automatic reg_sel_e decode_reg(input logic [ADDR_W-1:0] a);
    case (a)
      OFS_PARAM: decode_reg = SEL_PARAM;
      OFS_MCTRL: decode_reg = SEL_MCTRL;
      OFS_MSTAT: decode_reg = SEL_MSTAT;
      OFS_GIER:  decode_reg = SEL_GIER;
      OFS_GCR:   decode_reg = SEL_GCR;
      OFS_GSR:   decode_reg = SEL_GSR;
      OFS_TCR:   decode_reg = SEL_TCR;
      OFS_TSR:   decode_reg = SEL_TSR;
      OFS_RCR:   decode_reg = SEL_RCR;
      OFS_RSR:   decode_reg = SEL_RSR;
      default:   decode_reg = SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/ipc_mu_mailbox.sv
// One direction of data transfer: slot storage plus per-slot full flags.
module ipc_mu_mailbox #(
  parameter int CH = 4,
  parameter int DW = 32,
  localparam int IW = $clog2(CH)
) (
  input  logic          clk,
  input  logic          clr,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [IW-1:0] rd_idx,
  output logic [DW-1:0] rd_data,
  output logic [CH-1:0] full
);
  logic [DW-1:0] mem [CH];

  // Plain RAM: one write port, one registered read port, no reset.
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
    if (rd_en) rd_data <= mem[rd_idx];
  end

  for (genvar n = 0; n < CH; n++) begin : g_flag
    always_ff @(posedge clk) begin
      if (clr)                                     full[n] <= 1'b0;
      else if (wr_en && wr_idx == IW'(n))          full[n] <= 1'b1;
      else if (rd_en && rd_idx == IW'(n))          full[n] <= 1'b0;
    end
  end
endmodule

// File: rtl/ipc_mu_doorbell.sv
// One direction of doorbells: request bits on the sender, pending bits on the receiver.
module ipc_mu_doorbell #(
  parameter int CH = 4
) (
  input  logic          clk,
  input  logic          clr,
  input  logic [CH-1:0] raise,
  input  logic [CH-1:0] ack,
  output logic [CH-1:0] req_q,
  output logic [CH-1:0] pend_q
);
  always_ff @(posedge clk) begin
    if (clr) begin
      req_q  <= '0;
      pend_q <= '0;
    end else begin
      // A raise in the same cycle as an ack wins on both sides.
      pend_q <= (pend_q & ~ack) | raise;
      req_q  <= (req_q & ~(ack & pend_q)) | raise;
    end
  end
endmodule

// File: rtl/ipc_mu_side.sv
// Register port of one side: decode, enable masks, read mux, interrupt.
module ipc_mu_side import ipc_mu_pkg::*; #(
  parameter int CH = 4,
  parameter int DW = 32,
  localparam int IW = $clog2(CH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              busy,
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  output logic              irq,
  input  logic [CH-1:0]     gcr_q,
  input  logic [CH-1:0]     gsr_q,
  input  logic [CH-1:0]     tsr,
  input  logic [CH-1:0]     rsr,
  input  logic [DW-1:0]     rx_data,
  output logic [CH-1:0]     gcr_set,
  output logic [CH-1:0]     gsr_w1c,
  output logic              tx_wr,
  output logic [IW-1:0]     tx_idx,
  output logic              rx_rd,
  output logic [IW-1:0]     rx_idx,
  output logic              rst_req
);
  localparam logic [ADDR_W-1:0] TX_END = OFS_TX + ADDR_W'(4 * CH);
  localparam logic [ADDR_W-1:0] RX_END = OFS_RX + ADDR_W'(4 * CH);

  logic          wr, rd, aligned, hit_tx, hit_rx;
  reg_sel_e      sel;
  logic [CH-1:0] gier, tcr, rcr;
  logic [DW-1:0] mux, reg_q;
  logic          rx_sel_q;

  always_comb begin
    wr      = req && we;
    rd      = req && !we;
    aligned = (addr[1:0] == 2'b00);
    hit_tx  = aligned && addr >= OFS_TX && addr < TX_END;
    hit_rx  = aligned && addr >= OFS_RX && addr < RX_END;
    sel     = decode_reg(addr);
    tx_idx  = IW'((addr - OFS_TX) >> 2);
    rx_idx  = IW'((addr - OFS_RX) >> 2);
    tx_wr   = wr && hit_tx;
    rx_rd   = rd && hit_rx;
    gcr_set = (wr && sel == SEL_GCR) ? wdata[CH-1:0] : '0;
    gsr_w1c = (wr && sel == SEL_GSR) ? wdata[CH-1:0] : '0;
    rst_req = wr && sel == SEL_MCTRL && wdata[0];
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      gier <= '0;
      tcr  <= '0;
      rcr  <= '0;
    end else if (wr) begin
      case (sel)
        SEL_GIER: gier <= wdata[CH-1:0];
        SEL_TCR:  tcr  <= wdata[CH-1:0];
        SEL_RCR:  rcr  <= wdata[CH-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (sel)
      SEL_PARAM: mux = DW'({8'(CH), 8'(CH)});
      SEL_MCTRL: mux = DW'(busy);
      SEL_MSTAT: mux = DW'(busy);
      SEL_GIER:  mux = DW'(gier);
      SEL_GCR:   mux = DW'(gcr_q);
      SEL_GSR:   mux = DW'(gsr_q);
      SEL_TCR:   mux = DW'(tcr);
      SEL_TSR:   mux = DW'(tsr);
      SEL_RCR:   mux = DW'(rcr);
      SEL_RSR:   mux = DW'(rsr);
      default:   mux = '0;
    endcase
  end

  // Read path is reset only by the pin so status stays readable during a unit reset.
  always_ff @(posedge clk) begin
    if (rst) begin
      reg_q    <= '0;
      rx_sel_q <= 1'b0;
    end else if (rd) begin
      reg_q    <= mux;
      rx_sel_q <= hit_rx;
    end
  end

  assign rdata = rx_sel_q ? rx_data : reg_q;

  always_ff @(posedge clk) begin
    if (clr) irq <= 1'b0;
    else     irq <= |(gsr_q & gier) | |(rsr & rcr) | |(tsr & tcr);
  end
endmodule

// File: rtl/ipc_msg_unit.sv
module ipc_msg_unit import ipc_mu_pkg::*; #(
  parameter int CH         = 4,
  parameter int DW         = 32,
  parameter int RST_CYCLES = 4,
  localparam int IW = $clog2(CH),
  localparam int CW = $clog2(RST_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              a_req,
  input  logic              a_we,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DW-1:0]     a_wdata,
  output logic [DW-1:0]     a_rdata,
  output logic              a_irq,
  input  logic              b_req,
  input  logic              b_we,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DW-1:0]     b_wdata,
  output logic [DW-1:0]     b_rdata,
  output logic              b_irq
);
  logic          busy_q, clr;
  logic [CW-1:0] cnt_q;
  logic          a_rst_req, b_rst_req;

  logic [CH-1:0] ab_full, ba_full, ab_req, ab_pend, ba_req, ba_pend;
  logic [CH-1:0] a_gcr_set, a_gsr_w1c, b_gcr_set, b_gsr_w1c;
  logic          a_tx_wr, a_rx_rd, b_tx_wr, b_rx_rd;
  logic [IW-1:0] a_tx_idx, a_rx_idx, b_tx_idx, b_rx_idx;
  logic [DW-1:0] ab_rdata, ba_rdata;

  // Unit reset sequencer: holds all state cleared for RST_CYCLES cycles.
  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end else if (a_rst_req || b_rst_req) begin
      busy_q <= 1'b1;
      cnt_q  <= CW'(RST_CYCLES - 1);
    end
  end

  assign clr = rst || busy_q;

  ipc_mu_mailbox #(.CH(CH), .DW(DW)) u_mb_ab (
    .clk(clk), .clr(clr),
    .wr_en(a_tx_wr), .wr_idx(a_tx_idx), .wr_data(a_wdata),
    .rd_en(b_rx_rd), .rd_idx(b_rx_idx), .rd_data(ab_rdata), .full(ab_full));

  ipc_mu_mailbox #(.CH(CH), .DW(DW)) u_mb_ba (
    .clk(clk), .clr(clr),
    .wr_en(b_tx_wr), .wr_idx(b_tx_idx), .wr_data(b_wdata),
    .rd_en(a_rx_rd), .rd_idx(a_rx_idx), .rd_data(ba_rdata), .full(ba_full));

  ipc_mu_doorbell #(.CH(CH)) u_db_ab (
    .clk(clk), .clr(clr), .raise(a_gcr_set), .ack(b_gsr_w1c),
    .req_q(ab_req), .pend_q(ab_pend));

  ipc_mu_doorbell #(.CH(CH)) u_db_ba (
    .clk(clk), .clr(clr), .raise(b_gcr_set), .ack(a_gsr_w1c),
    .req_q(ba_req), .pend_q(ba_pend));

  ipc_mu_side #(.CH(CH), .DW(DW)) u_side_a (
    .clk(clk), .rst(rst), .clr(clr), .busy(busy_q),
    .req(a_req), .we(a_we), .addr(a_addr), .wdata(a_wdata),
    .rdata(a_rdata), .irq(a_irq),
    .gcr_q(ab_req), .gsr_q(ba_pend), .tsr(~ab_full), .rsr(ba_full),
    .rx_data(ba_rdata), .gcr_set(a_gcr_set), .gsr_w1c(a_gsr_w1c),
    .tx_wr(a_tx_wr), .tx_idx(a_tx_idx), .rx_rd(a_rx_rd), .rx_idx(a_rx_idx),
    .rst_req(a_rst_req));

  ipc_mu_side #(.CH(CH), .DW(DW)) u_side_b (
    .clk(clk), .rst(rst), .clr(clr), .busy(busy_q),
    .req(b_req), .we(b_we), .addr(b_addr), .wdata(b_wdata),
    .rdata(b_rdata), .irq(b_irq),
    .gcr_q(ba_req), .gsr_q(ab_pend), .tsr(~ba_full), .rsr(ab_full),
    .rx_data(ab_rdata), .gcr_set(b_gcr_set), .gsr_w1c(b_gsr_w1c),
    .tx_wr(b_tx_wr), .tx_idx(b_tx_idx), .rx_rd(b_rx_rd), .rx_idx(b_rx_idx),
    .rst_req(b_rst_req));
endmodule

// File: rtl/ipc_msg_unit_chk.sv
module ipc_msg_unit_chk import ipc_mu_pkg::*; #(
  parameter int CH = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              a_req,
  input logic              a_we,
  input logic [ADDR_W-1:0] a_addr,
  input logic [CH-1:0]     a_wbits,
  input logic              b_req,
  input logic              b_we,
  input logic [ADDR_W-1:0] b_addr,
  input logic              a_irq,
  input logic              b_irq,
  input logic [CH-1:0]     ab_full,
  input logic [CH-1:0]     ba_full,
  input logic [CH-1:0]     ab_pend,
  input logic [CH-1:0]     ba_pend,
  input logic [CH-1:0]     ab_req
);
  for (genvar n = 0; n < CH; n++) begin : g_ch
    // R2: a transmit write from side A marks the slot full on side B.
    a_r2_tx_fills: assert property (@(posedge clk) disable iff (rst)
      (a_req && a_we && a_addr == OFS_TX + ADDR_W'(4*n) && !busy) |=> ab_full[n]);

    // R3: a receive read on side B empties the slot unless A refills it.
    a_r3_rx_empties: assert property (@(posedge clk) disable iff (rst)
      (b_req && !b_we && b_addr == OFS_RX + ADDR_W'(4*n) && !busy &&
       !(a_req && a_we && a_addr == OFS_TX + ADDR_W'(4*n))) |=> !ab_full[n]);

    // R10: a raise always leaves request and pending set, even against a clear.
    a_r10_raise_wins: assert property (@(posedge clk) disable iff (rst)
      (a_req && a_we && a_addr == OFS_GCR && a_wbits[n] && !busy) |=> (ab_pend[n] && ab_req[n]));
  end

  // R11: state is held clear while the unit reset runs.
  a_r11_state_clear: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> (ab_full == '0 && ba_full == '0 && ab_pend == '0 && ba_pend == '0));

  // R6: no interrupt while the unit reset runs.
  a_r6_irq_quiet: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> (!a_irq && !b_irq));
endmodule

bind ipc_msg_unit ipc_msg_unit_chk #(.CH(CH)) u_chk (
  .clk(clk), .rst(rst), .busy(busy_q),
  .a_req(a_req), .a_we(a_we), .a_addr(a_addr), .a_wbits(a_wdata[CH-1:0]),
  .b_req(b_req), .b_we(b_we), .b_addr(b_addr),
  .a_irq(a_irq), .b_irq(b_irq),
  .ab_full(ab_full), .ba_full(ba_full), .ab_pend(ab_pend), .ba_pend(ba_pend),
  .ab_req(ab_req));

// File: tb/sim_ipc_msg_unit.sv
`timescale 1ns/1ps
module sim_ipc_msg_unit;
  logic clk = 1'b0;
  logic rst;
  logic a_req, a_we, b_req, b_we;
  logic [11:0] a_addr, b_addr;
  logic [31:0] a_wdata, b_wdata, a_rdata, b_rdata;
  logic a_irq, b_irq;

  int checks = 0;
  int errors = 0;

  localparam logic [11:0] PARAM = 12'h004, MCTRL = 12'h008, MSTAT = 12'h00C;
  localparam logic [11:0] GIER = 12'h110, GCR = 12'h114, GSR = 12'h118;
  localparam logic [11:0] TCR = 12'h120, TSR = 12'h124, RCR = 12'h128, RSR = 12'h12C;
  localparam logic [11:0] TX = 12'h200, RX = 12'h280;

  always #5 clk = ~clk;

  ipc_msg_unit u0 (
    .clk(clk), .rst(rst),
    .a_req(a_req), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata),
    .a_rdata(a_rdata), .a_irq(a_irq),
    .b_req(b_req), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata),
    .b_rdata(b_rdata), .b_irq(b_irq));

  // Scoreboard queues of expected read data
  logic [31:0] qa_exp[$], qb_exp[$];
  string       qa_tag[$], qb_tag[$];
  logic        a_rv = 1'b0, b_rv = 1'b0;

  always @(posedge clk) begin
    a_rv <= a_req && !a_we;
    b_rv <= b_req && !b_we;
  end

  task automatic chk(input string tg, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tg, act, exp);
    end
  endtask

  // Monitor: compares each read response against the queued expectation
  always @(negedge clk) begin
    if (a_rv && qa_exp.size() > 0) chk({"A ", qa_tag.pop_front()}, a_rdata, qa_exp.pop_front());
    if (b_rv && qb_exp.size() > 0) chk({"B ", qb_tag.pop_front()}, b_rdata, qb_exp.pop_front());
  end

  // Driver: one cycle on both ports, called just after a falling edge
  task automatic go(input logic ar, input logic aw, input logic [11:0] aad, input logic [31:0] awd,
                    input logic br, input logic bw, input logic [11:0] bad, input logic [31:0] bwd,
                    input logic [31:0] aex, input logic [31:0] bex, input string tg);
    a_req = ar; a_we = aw; a_addr = aad; a_wdata = awd;
    b_req = br; b_we = bw; b_addr = bad; b_wdata = bwd;
    if (ar && !aw) begin qa_exp.push_back(aex); qa_tag.push_back(tg); end
    if (br && !bw) begin qb_exp.push_back(bex); qb_tag.push_back(tg); end
    @(posedge clk);
    @(negedge clk);
    a_req = 1'b0; b_req = 1'b0;
  endtask

  task automatic wa(input logic [11:0] ad, input logic [31:0] d);
    go(1, 1, ad, d, 0, 0, 12'h0, 32'h0, 32'h0, 32'h0, "");
  endtask
  task automatic wb(input logic [11:0] ad, input logic [31:0] d);
    go(0, 0, 12'h0, 32'h0, 1, 1, ad, d, 32'h0, 32'h0, "");
  endtask
  task automatic ra(input logic [11:0] ad, input logic [31:0] ex, input string tg);
    go(1, 0, ad, 32'h0, 0, 0, 12'h0, 32'h0, ex, 32'h0, tg);
  endtask
  task automatic rb(input logic [11:0] ad, input logic [31:0] ex, input string tg);
    go(0, 0, 12'h0, 32'h0, 1, 0, ad, 32'h0, 32'h0, ex, tg);
  endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    a_req = 0; a_we = 0; a_addr = '0; a_wdata = '0;
    b_req = 0; b_we = 0; b_addr = '0; b_wdata = '0;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R8: reset state
    chk("R8 a_rdata", a_rdata, 32'h0);
    chk("R8 a_irq", {31'h0, a_irq}, 32'h0);
    chk("R8 b_irq", {31'h0, b_irq}, 32'h0);
    ra(TSR, 32'hF, "R8 tsr");
    rb(TSR, 32'hF, "R8 tsr");
    ra(RSR, 32'h0, "R8 rsr");
    ra(GSR, 32'h0, "R8 gsr");
    ra(GCR, 32'h0, "R8 gcr");
    ra(MSTAT, 32'h0, "R8 mstat");
    // R1: parameter word
    ra(PARAM, 32'h0000_0404, "R1 param");
    rb(PARAM, 32'h0000_0404, "R1 param");

    // R2/R3: data A->B slot 2, B->A slot 3
    wa(TX + 12'h8, 32'hDEAD_BEEF);
    rb(RSR, 32'h4, "R2 peer full");
    ra(TSR, 32'hB, "R2 writer empty");
    rb(RX + 12'h8, 32'hDEAD_BEEF, "R2 data");
    rb(RSR, 32'h0, "R3 full cleared");
    ra(TSR, 32'hF, "R3 empty restored");
    wb(TX + 12'hC, 32'h1234_5678);
    ra(RSR, 32'h8, "R2 B->A full");
    ra(RX + 12'hC, 32'h1234_5678, "R2 B->A data");
    rb(TSR, 32'hF, "R3 B empty restored");

    // R4/R5: doorbells
    wa(GCR, 32'h5);
    rb(GSR, 32'h5, "R4 pending");
    ra(GCR, 32'h5, "R4 request held");
    wb(GSR, 32'h1);
    rb(GSR, 32'h4, "R5 w1c partial");
    ra(GCR, 32'h4, "R5 request drops");
    wb(GSR, 32'h4);
    rb(GSR, 32'h0, "R5 w1c rest");
    ra(GCR, 32'h0, "R5 request gone");

    // R6: interrupts
    wb(GIER, 32'h2);
    idle(1);
    chk("R6 b_irq masked idle", {31'h0, b_irq}, 32'h0);
    wa(GCR, 32'h2);
    idle(1);
    chk("R6 b_irq doorbell", {31'h0, b_irq}, 32'h1);
    wb(GSR, 32'h2);
    idle(1);
    chk("R6 b_irq cleared", {31'h0, b_irq}, 32'h0);
    wa(RCR, 32'h1);
    wb(TX, 32'h7);
    idle(1);
    chk("R6 a_irq rx full", {31'h0, a_irq}, 32'h1);
    ra(RX, 32'h7, "R6 rx data");
    idle(1);
    chk("R6 a_irq rx drained", {31'h0, a_irq}, 32'h0);
    wa(TCR, 32'h8);
    idle(1);
    chk("R6 a_irq tx empty", {31'h0, a_irq}, 32'h1);
    wa(TCR, 32'h0);
    idle(1);
    chk("R6 a_irq tx masked", {31'h0, a_irq}, 32'h0);

    // R7: writes to read-only locations
    wa(PARAM, 32'hFFFF_FFFF);
    ra(PARAM, 32'h0000_0404, "R7 param");
    wa(TSR, 32'h0);
    ra(TSR, 32'hF, "R7 tsr");
    wa(RX, 32'h1);
    ra(RSR, 32'h0, "R7 rx write a");
    rb(RSR, 32'h0, "R7 rx write b");
    wa(MSTAT, 32'h1);
    ra(MSTAT, 32'h0, "R7 mstat");

    // R9: same-cycle transmit write and peer receive read, slot 1
    wa(TX + 12'h4, 32'h0000_AAAA);
    go(1, 1, TX + 12'h4, 32'h0000_BBBB, 1, 0, RX + 12'h4, 32'h0, 32'h0, 32'h0000_AAAA, "R9 old word");
    rb(RSR, 32'h2, "R9 still full");
    ra(TSR, 32'hD, "R9 still busy");
    rb(RX + 12'h4, 32'h0000_BBBB, "R9 new word");

    // R10: same-cycle raise and clear of doorbell 0
    wa(GCR, 32'h1);
    go(1, 1, GCR, 32'h1, 1, 1, GSR, 32'h1, 32'h0, 32'h0, "");
    rb(GSR, 32'h1, "R10 pending kept");
    ra(GCR, 32'h1, "R10 request kept");
    wb(GSR, 32'h1);

    // R11: unit reset request
    wa(TX, 32'h5);
    wa(GIER, 32'hF);
    wa(MCTRL, 32'h1);
    ra(MSTAT, 32'h1, "R11 status busy");
    ra(MCTRL, 32'h1, "R11 ctrl busy");
    idle(6);
    ra(MSTAT, 32'h0, "R11 done");
    rb(RSR, 32'h0, "R11 full cleared");
    ra(GIER, 32'h0, "R11 enable cleared");
    ra(TSR, 32'hF, "R11 empty restored");

    idle(2);
    finish_run();
  end
endmodule